// File: doc/BRIEF.md
# Control packet stream parser

The parser takes 32-bit words over a valid/ready input channel and splits them into control packets. A packet opens with two header words. The first word names the packet type and packet ID. The second gives a stream ID, an opcode, a beat count and a 20-bit target address. Write and block-write packets then carry a payload of beat count plus one words. Read packets carry no payload. Each header word has a parity bit, and that bit is checked before any field taken from the word is kept.

Each packet that parses cleanly is presented as one command: the decoded fields, a length, and up to four data words. The command is held on the output until the consumer accepts it, and no input word is taken while it waits. Sticky flags report three conditions: a parity failure, an end-of-stream marker that arrives before the payload is complete, and a reserved opcode. A parity failure or an early end of stream stops the parser until a synchronous clear. A separate warning flag reports an end-of-stream marker that arrives on a lone stream header word.

Top module: `ctrl_pkt_parser`

## Requirements
- R1: After reset, in_ready_o is 1, cmd_valid_o is 0, and err_parity_o, err_trunc_o, err_opcode_o and warn_trail_o are all 0.
- R2: The first word of a packet is the stream header. The command reports packet type from bits [14:12] of that word and packet ID from bits [7:0].
- R3: The second word is the control header. The command reports stream ID from bits [30:24], opcode from bits [23:22] and address from bits [19:0].
- R4: cmd_len_o equals the beats field (control header bits [21:20]) plus one, for every opcode.
- R5: For opcode 0 (write) and opcode 2 (block write), exactly cmd_len_o payload words follow the control header. Payload word j appears on cmd_data_o[32*j+31:32*j]. For opcode 1 (read), no payload is taken, and cmd_data_o is all zero.
- R6: Bit 31 of each header word makes the whole word even parity (EVEN_PARITY=1). If either header word fails this check, err_parity_o is set, no command is emitted, and in_ready_o stays 0 until clear_i.
- R7: If in_last_i comes with a write or block-write control header, or with any payload word before the last one, err_trunc_o is set and the parser halts with in_ready_o at 0. If in_last_i comes with the final payload word, or with a read control header, the packet completes normally and no flag is raised.
- R8: While cmd_valid_o is 1, in_ready_o is 0.
- R9: cmd_valid_o and every cmd_* field stay unchanged until a cycle in which cmd_ready_i is 1. In that cycle the command is consumed, and the parser waits for a new stream header.
- R10: Opcode 3 sets the sticky err_opcode_o. The packet is emitted with no payload, and parsing then continues.
- R11: If in_last_i comes with a stream header word that has good parity, warn_trail_o is set and the word is dropped. The next word is taken as a stream header.
- R12: clear_i, sampled on a clock edge, clears all four flags, discards any partly received packet or pending command, and returns the parser to waiting for a stream header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of flags and parse state |
| in_data_i | input | 32 | Input stream word |
| in_valid_i | input | 1 | Input word valid |
| in_last_i | input | 1 | End of stream, marks the current word |
| in_ready_o | output | 1 | Parser accepts the input word |
| cmd_valid_o | output | 1 | Decoded command present |
| cmd_ready_i | input | 1 | Consumer accepts the command |
| cmd_pkt_type_o | output | 3 | Packet type |
| cmd_pkt_id_o | output | 8 | Packet ID |
| cmd_stream_id_o | output | 7 | Stream ID |
| cmd_opcode_o | output | 2 | Opcode: 0 write, 1 read, 2 block write, 3 reserved |
| cmd_len_o | output | 3 | Beats plus one |
| cmd_addr_o | output | 20 | Target address |
| cmd_data_o | output | 128 | Payload words, word j in bits [32j+31:32j] |
| err_parity_o | output | 1 | Sticky header parity error |
| err_trunc_o | output | 1 | Sticky truncated packet error |
| err_opcode_o | output | 1 | Sticky reserved opcode error |
| warn_trail_o | output | 1 | Sticky trailing data warning |

## Verification
Getting into the halted error states takes a corrupted parity bit or an end-of-stream marker placed before the final payload word. Once there, in_ready_o never rises again, so a normal handshaking stimulus task would wait forever. To cover this, the bench drives a word for a few cycles without waiting for the handshake, then pulses clear_i. The harder case is a clear that lands in the middle of a payload. The bench sends a stream header, a control header and one payload word, issues the clear, and then sends a complete packet that must parse as new. The consumer's ready line follows a fixed pattern that is not periodic with the packets, so commands are held for varying numbers of cycles.

// File: rtl/ctrl_pkt_pkg.sv
package ctrl_pkt_pkg;
  localparam int WORD_W    = 32;
  localparam int BEAT_W    = 2;
  localparam int MAX_WORDS = 1 << BEAT_W;
  localparam int LEN_W     = BEAT_W + 1;

  localparam int TYPE_LSB  = 12;
  localparam int TYPE_W    = 3;
  localparam int ID_W      = 8;
  localparam int SID_LSB   = 24;
  localparam int SID_W     = 7;
  localparam int OP_LSB    = 22;
  localparam int OP_W      = 2;
  localparam int BEAT_LSB  = 20;
  localparam int ADDR_W    = 20;

  localparam logic [OP_W-1:0] OP_WRITE = 2'd0;
  localparam logic [OP_W-1:0] OP_READ  = 2'd1;
  localparam logic [OP_W-1:0] OP_BLOCK = 2'd2;
  localparam logic [OP_W-1:0] OP_RSVD  = 2'd3;

  typedef enum logic [2:0] {
    S_WAIT_SH,
    S_WAIT_CH,
    S_PAYLOAD,
    S_EMIT,
    S_ERROR
  } parse_state_e;
endpackage

// File: rtl/cpp_parity_chk.sv
module cpp_parity_chk #(
  parameter int  WIDTH       = 32,
  parameter bit  EVEN_PARITY = 1'b1
) (
  input  logic [WIDTH-1:0] word_i,
  output logic             ok_o
);
  generate
    if (EVEN_PARITY) begin : g_even
      assign ok_o = ~^word_i;
    end else begin : g_odd
      assign ok_o = ^word_i;
    end
  endgenerate
endmodule

// File: rtl/cpp_payload_buf.sv
module cpp_payload_buf #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   wr_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [WIDTH-1:0]       data_i,
  output logic [DEPTH*WIDTH-1:0] data_o
);
  generate
    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
      logic [WIDTH-1:0] slot_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 slot_q <= '0;
        else if (clr_i)                              slot_q <= '0;
        else if (wr_i && (idx_i == IDX_W'(j)))       slot_q <= data_i;
      end
      assign data_o[j*WIDTH +: WIDTH] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/ctrl_pkt_parser.sv
module ctrl_pkt_parser
  import ctrl_pkt_pkg::*;
#(
  parameter bit EVEN_PARITY = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic [WORD_W-1:0]           in_data_i,
  input  logic                        in_valid_i,
  input  logic                        in_last_i,
  output logic                        in_ready_o,
  output logic                        cmd_valid_o,
  input  logic                        cmd_ready_i,
  output logic [TYPE_W-1:0]           cmd_pkt_type_o,
  output logic [ID_W-1:0]             cmd_pkt_id_o,
  output logic [SID_W-1:0]            cmd_stream_id_o,
  output logic [OP_W-1:0]             cmd_opcode_o,
  output logic [LEN_W-1:0]            cmd_len_o,
  output logic [ADDR_W-1:0]           cmd_addr_o,
  output logic [MAX_WORDS*WORD_W-1:0] cmd_data_o,
  output logic                        err_parity_o,
  output logic                        err_trunc_o,
  output logic                        err_opcode_o,
  output logic                        warn_trail_o
);
  parse_state_e state_q, state_d;

  logic              par_ok, acc;
  logic              sh_ld, ch_ld, pay_wr;
  logic              perr_set, trunc_set, oper_set, trail_set;
  logic [OP_W-1:0]   in_op;
  logic              in_has_pay;
  logic [BEAT_W-1:0] beats_q, cnt_q;
  logic [TYPE_W-1:0] type_q;
  logic [ID_W-1:0]   id_q;
  logic [SID_W-1:0]  sid_q;
  logic [OP_W-1:0]   op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              perr_q, trunc_q, oper_q, trail_q;

  cpp_parity_chk #(.WIDTH(WORD_W), .EVEN_PARITY(EVEN_PARITY)) i_par (
    .word_i (in_data_i),
    .ok_o   (par_ok)
  );

  assign in_ready_o = (state_q == S_WAIT_SH) || (state_q == S_WAIT_CH) ||
                      (state_q == S_PAYLOAD);
  assign acc        = in_valid_i && in_ready_o;
  assign in_op      = in_data_i[OP_LSB +: OP_W];
  assign in_has_pay = (in_op == OP_WRITE) || (in_op == OP_BLOCK);

  always_comb begin
    state_d   = state_q;
    sh_ld     = 1'b0;
    ch_ld     = 1'b0;
    pay_wr    = 1'b0;
    perr_set  = 1'b0;
    trunc_set = 1'b0;
    oper_set  = 1'b0;
    trail_set = 1'b0;
    case (state_q)
      S_WAIT_SH: if (acc) begin
        if (!par_ok) begin
          perr_set = 1'b1;
          state_d  = S_ERROR;
        end else if (in_last_i) begin
          trail_set = 1'b1;           // lone header word: drop it
        end else begin
          sh_ld   = 1'b1;
          state_d = S_WAIT_CH;
        end
      end
      S_WAIT_CH: if (acc) begin
        if (!par_ok) begin
          perr_set = 1'b1;
          state_d  = S_ERROR;
        end else begin
          ch_ld = 1'b1;
          if (in_has_pay) begin
            if (in_last_i) begin
              trunc_set = 1'b1;
              state_d   = S_ERROR;
            end else begin
              state_d = S_PAYLOAD;
            end
          end else begin
            oper_set = (in_op == OP_RSVD);
            state_d  = S_EMIT;
          end
        end
      end
      S_PAYLOAD: if (acc) begin
        pay_wr = 1'b1;
        if (cnt_q == beats_q) begin
          state_d = S_EMIT;
        end else if (in_last_i) begin
          trunc_set = 1'b1;
          state_d   = S_ERROR;
        end
      end
      S_EMIT:  if (cmd_ready_i) state_d = S_WAIT_SH;
      S_ERROR: state_d = S_ERROR;
      default: state_d = S_WAIT_SH;
    endcase
    if (clear_i) state_d = S_WAIT_SH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_WAIT_SH;
      type_q  <= '0;
      id_q    <= '0;
      sid_q   <= '0;
      op_q    <= '0;
      beats_q <= '0;
      addr_q  <= '0;
      cnt_q   <= '0;
      perr_q  <= 1'b0;
      trunc_q <= 1'b0;
      oper_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (sh_ld) begin
        type_q <= in_data_i[TYPE_LSB +: TYPE_W];
        id_q   <= in_data_i[0 +: ID_W];
      end
      if (ch_ld) begin
        sid_q   <= in_data_i[SID_LSB +: SID_W];
        op_q    <= in_op;
        beats_q <= in_data_i[BEAT_LSB +: BEAT_W];
        addr_q  <= in_data_i[0 +: ADDR_W];
        cnt_q   <= '0;
      end else if (pay_wr) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (clear_i) begin
        perr_q  <= 1'b0;
        trunc_q <= 1'b0;
        oper_q  <= 1'b0;
        trail_q <= 1'b0;
      end else begin
        perr_q  <= perr_q  | perr_set;
        trunc_q <= trunc_q | trunc_set;
        oper_q  <= oper_q  | oper_set;
        trail_q <= trail_q | trail_set;
      end
    end
  end

  cpp_payload_buf #(.WIDTH(WORD_W), .DEPTH(MAX_WORDS)) i_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ch_ld),
    .wr_i   (pay_wr),
    .idx_i  (cnt_q),
    .data_i (in_data_i),
    .data_o (cmd_data_o)
  );

  assign cmd_valid_o     = (state_q == S_EMIT);
  assign cmd_pkt_type_o  = type_q;
  assign cmd_pkt_id_o    = id_q;
  assign cmd_stream_id_o = sid_q;
  assign cmd_opcode_o    = op_q;
  assign cmd_addr_o      = addr_q;
  assign cmd_len_o       = {1'b0, beats_q} + 1'b1;
  assign err_parity_o    = perr_q;
  assign err_trunc_o     = trunc_q;
  assign err_opcode_o    = oper_q;
  assign warn_trail_o    = trail_q;
endmodule

// File: rtl/cpp_chk.sv
module cpp_chk
  import ctrl_pkt_pkg::*;
(
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        clear_i,
  input logic                        in_ready_o,
  input logic                        cmd_valid_o,
  input logic                        cmd_ready_i,
  input logic [OP_W-1:0]             cmd_opcode_o,
  input logic [LEN_W-1:0]            cmd_len_o,
  input logic [ADDR_W-1:0]           cmd_addr_o,
  input logic [MAX_WORDS*WORD_W-1:0] cmd_data_o,
  input logic                        err_parity_o,
  input logic                        err_trunc_o,
  input logic                        err_opcode_o
);
  // R8
  ready_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !in_ready_o);

  // R9
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && !clear_i) |=>
      (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_data_o) && $stable(cmd_opcode_o)));

  // R6
  parity_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_parity_o && !clear_i) |=> err_parity_o);

  // R7
  halt_on_error_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_parity_o || err_trunc_o) |-> (!in_ready_o && !cmd_valid_o));

  // R4
  len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_len_o != '0 && cmd_len_o <= LEN_W'(MAX_WORDS)));

  // R10
  rsvd_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_opcode_o == OP_RSVD) |-> err_opcode_o);

  // R12
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!err_parity_o && !err_trunc_o && !err_opcode_o && in_ready_o));
endmodule

bind ctrl_pkt_parser cpp_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .clear_i      (clear_i),
  .in_ready_o   (in_ready_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_opcode_o (cmd_opcode_o),
  .cmd_len_o    (cmd_len_o),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_data_o   (cmd_data_o),
  .err_parity_o (err_parity_o),
  .err_trunc_o  (err_trunc_o),
  .err_opcode_o (err_opcode_o)
);

// File: tb/test_ctrl_pkt_parser.sv
`timescale 1ns/1ps
module test_ctrl_pkt_parser;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clear_i = 1'b0;
  logic [31:0]  in_data_i = '0;
  logic         in_valid_i = 1'b0;
  logic         in_last_i = 1'b0;
  logic         in_ready_o;
  logic         cmd_valid_o;
  logic         cmd_ready_i = 1'b0;
  logic [2:0]   cmd_pkt_type_o;
  logic [7:0]   cmd_pkt_id_o;
  logic [6:0]   cmd_stream_id_o;
  logic [1:0]   cmd_opcode_o;
  logic [2:0]   cmd_len_o;
  logic [19:0]  cmd_addr_o;
  logic [127:0] cmd_data_o;
  logic         err_parity_o, err_trunc_o, err_opcode_o, warn_trail_o;

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;

  ctrl_pkt_parser i_ctrl_pkt_parser (.*);

  always #10 clk_i = ~clk_i;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_st = 0;   // 0 wait-stream-hdr, 1 wait-ctrl-hdr, 2 payload, 3 emit, 4 halted
  logic [31:0] m_sh, m_ch;
  logic [31:0] m_q[$];
  int          m_len;
  bit          m_perr, m_trunc, m_oper, m_trail;

  function automatic bit good_par(input logic [31:0] w);
    return ~^w;
  endfunction

  function automatic bit m_ready();
    return (m_st == 0 || m_st == 1 || m_st == 2);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_perr = 0; m_trunc = 0; m_oper = 0; m_trail = 0;
      m_q.delete();
    end else if (clear_i) begin
      m_st = 0; m_perr = 0; m_trunc = 0; m_oper = 0; m_trail = 0;
    end else begin
      bit a;
      a = in_valid_i && m_ready();
      case (m_st)
        0: if (a) begin
          if (!good_par(in_data_i)) begin m_perr = 1; m_st = 4; end
          else if (in_last_i) m_trail = 1;
          else begin m_sh = in_data_i; m_st = 1; end
        end
        1: if (a) begin
          if (!good_par(in_data_i)) begin m_perr = 1; m_st = 4; end
          else begin
            m_ch = in_data_i;
            m_len = int'(in_data_i[21:20]) + 1;
            m_q.delete();
            if (in_data_i[23:22] == 2'd0 || in_data_i[23:22] == 2'd2) begin
              if (in_last_i) begin m_trunc = 1; m_st = 4; end
              else m_st = 2;
            end else begin
              if (in_data_i[23:22] == 2'd3) m_oper = 1;
              m_st = 3;
            end
          end
        end
        2: if (a) begin
          m_q.push_back(in_data_i);
          if (m_q.size() == m_len) m_st = 3;
          else if (in_last_i) begin m_trunc = 1; m_st = 4; end
        end
        3: if (cmd_ready_i) m_st = 0;
        default: ;
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni) begin
      logic [127:0] exp_data;
      check("R8 in_ready",    128'(in_ready_o),   128'(m_ready()));
      check("R9 cmd_valid",   128'(cmd_valid_o),  128'(m_st == 3));
      check("R6 err_parity",  128'(err_parity_o), 128'(m_perr));
      check("R7 err_trunc",   128'(err_trunc_o),  128'(m_trunc));
      check("R10 err_opcode", 128'(err_opcode_o), 128'(m_oper));
      check("R11 warn_trail", 128'(warn_trail_o), 128'(m_trail));
      if (m_st == 3) begin
        exp_data = '0;
        foreach (m_q[j]) exp_data[32*j +: 32] = m_q[j];
        check("R2 pkt_type",  128'(cmd_pkt_type_o),  128'(m_sh[14:12]));
        check("R2 pkt_id",    128'(cmd_pkt_id_o),    128'(m_sh[7:0]));
        check("R3 stream_id", 128'(cmd_stream_id_o), 128'(m_ch[30:24]));
        check("R3 opcode",    128'(cmd_opcode_o),    128'(m_ch[23:22]));
        check("R3 addr",      128'(cmd_addr_o),      128'(m_ch[19:0]));
        check("R4 len",       128'(cmd_len_o),       128'(m_len));
        check("R5 data",      cmd_data_o,            exp_data);
      end
    end
  end

  // consumer ready pattern, drifting relative to packets
  always @(negedge clk_i) cmd_ready_i <= ((cyc % 7) != 2) && ((cyc % 5) != 4);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 50000) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mk_sh(input logic [2:0] t, input logic [7:0] id);
    logic [31:0] w;
    w = '0; w[14:12] = t; w[7:0] = id; w[31] = ^w[30:0];
    return w;
  endfunction

  function automatic logic [31:0] mk_ch(input logic [6:0] sid, input logic [1:0] op,
                                        input logic [1:0] bt, input logic [19:0] ad);
    logic [31:0] w;
    w = {1'b0, sid, op, bt, ad}; w[31] = ^w[30:0];
    return w;
  endfunction

  task automatic send_word(input logic [31:0] w, input logic last);
    @(negedge clk_i);
    in_data_i = w; in_last_i = last; in_valid_i = 1'b1;
    while (!in_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1 in_valid_i = 1'b0; in_last_i = 1'b0;
  endtask

  // present a word without waiting for a handshake
  task automatic poke_word(input logic [31:0] w);
    @(negedge clk_i);
    in_data_i = w; in_valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clear_i = 1'b1;
    @(negedge clk_i); clear_i = 1'b0;
    check("R12 ready after clear", 128'(in_ready_o), 128'(1));
    check("R12 flags after clear",
          128'({err_parity_o, err_trunc_o, err_opcode_o, warn_trail_o}), 128'(0));
  endtask

  // full packet; last_on_end marks the final word with in_last_i
  task automatic send_pkt(input logic [2:0] t, input logic [7:0] id, input logic [6:0] sid,
                          input logic [1:0] op, input logic [1:0] bt, input logic [19:0] ad,
                          input bit last_on_end);
    bit has_pay;
    has_pay = (op == 2'd0) || (op == 2'd2);
    send_word(mk_sh(t, id), 1'b0);
    send_word(mk_ch(sid, op, bt, ad), last_on_end && !has_pay);
    if (has_pay)
      for (int j = 0; j <= int'(bt); j++)
        send_word(32'hC000_0000 + {id, 16'h0} + 32'(j * 17 + 1), last_on_end && (j == int'(bt)));
  endtask

  task automatic wait_idle();
    repeat (12) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state, checked while reset is held and just after release
    check("R1 ready in reset", 128'(in_ready_o), 128'(1));
    check("R1 valid in reset", 128'(cmd_valid_o), 128'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 flags after reset",
          128'({err_parity_o, err_trunc_o, err_opcode_o, warn_trail_o}), 128'(0));

    // R2 R3 R4 R5 main traffic
    send_pkt(3'd2, 8'd3, 7'd0, 2'd0, 2'd0, 20'h1F000, 1'b0);
    send_pkt(3'd5, 8'hA7, 7'd9, 2'd2, 2'd3, 20'h1F020, 1'b0);
    send_pkt(3'd1, 8'h40, 7'd2, 2'd1, 2'd3, 20'h00400, 1'b0);
    send_pkt(3'd7, 8'hFF, 7'h7F, 2'd2, 2'd1, 20'hFFFFF, 1'b1);  // R7 last on final payload word
    send_pkt(3'd0, 8'h00, 7'h15, 2'd1, 2'd0, 20'h00001, 1'b1);  // R7 last on read header
    send_pkt(3'd4, 8'h5A, 7'h33, 2'd0, 2'd2, 20'hABCDE, 1'b0);
    wait_idle();

    // R10 reserved opcode, parsing continues
    send_pkt(3'd6, 8'h11, 7'h22, 2'd3, 2'd2, 20'h12345, 1'b0);
    send_pkt(3'd2, 8'h12, 7'h01, 2'd0, 2'd1, 20'h00100, 1'b0);
    wait_idle();
    check("R10 flag held", 128'(err_opcode_o), 128'(1));
    pulse_clear();

    // R11 lone stream header with last, then a normal packet
    send_word(mk_sh(3'd3, 8'h77), 1'b1);
    send_pkt(3'd3, 8'h78, 7'h05, 2'd2, 2'd0, 20'h00ABC, 1'b0);
    wait_idle();
    check("R11 flag held", 128'(warn_trail_o), 128'(1));
    pulse_clear();

    // R6 bad parity on stream header
    send_word(mk_sh(3'd1, 8'h01) ^ 32'h8000_0000, 1'b0);
    poke_word(mk_ch(7'd1, 2'd1, 2'd0, 20'h1));
    check("R6 halted after stream hdr", 128'({in_ready_o, cmd_valid_o, err_parity_o}), 128'(3'b001));
    pulse_clear();

    // R6 bad parity on control header
    send_word(mk_sh(3'd1, 8'h02), 1'b0);
    send_word(mk_ch(7'd4, 2'd0, 2'd1, 20'h2) ^ 32'h0000_0100, 1'b0);
    poke_word(32'h1);
    check("R6 halted after ctrl hdr", 128'({in_ready_o, cmd_valid_o, err_parity_o}), 128'(3'b001));
    pulse_clear();

    // R7 truncated payload
    send_word(mk_sh(3'd2, 8'h09), 1'b0);
    send_word(mk_ch(7'd8, 2'd0, 2'd2, 20'h333), 1'b0);
    send_word(32'hDEAD_0001, 1'b0);
    send_word(32'hDEAD_0002, 1'b1);
    poke_word(32'h5);
    check("R7 truncated payload", 128'({in_ready_o, cmd_valid_o, err_trunc_o}), 128'(3'b001));
    pulse_clear();

    // R7 last on block-write control header
    send_word(mk_sh(3'd2, 8'h0A), 1'b0);
    send_word(mk_ch(7'd8, 2'd2, 2'd0, 20'h444), 1'b1);
    check("R7 truncated at ctrl hdr", 128'({in_ready_o, err_trunc_o}), 128'(2'b01));
    pulse_clear();

    // R12 clear in the middle of a payload, then a fresh packet
    send_word(mk_sh(3'd5, 8'h20), 1'b0);
    send_word(mk_ch(7'd3, 2'd2, 2'd3, 20'h55555), 1'b0);
    send_word(32'hBAD0_0000, 1'b0);
    pulse_clear();
    send_pkt(3'd1, 8'h21, 7'h44, 2'd0, 2'd1, 20'h66666, 1'b0);
    wait_idle();
    check("R12 no flags after fresh packet",
          128'({err_parity_o, err_trunc_o, err_opcode_o, warn_trail_o}), 128'(0));

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule